// File: doc/BRIEF.md
# Request Completion Timeout Tracker

This block keeps watch over outstanding non-posted requests, each named by a small tag. When a request goes out, the tag's slot is armed with a countdown. A completion that later arrives for that tag disarms the slot. If the countdown reaches zero first, the block assumes the completion was lost. What happens next depends on a control bit. With resend enabled, the tracker asks the request path to reissue the request once and restarts the countdown. With resend disabled, or on a second expiry, the tag is retired and a timeout error is raised.

Time is counted in microsecond ticks taken from a clock prescaler. A 4-bit range field picks the countdown length. The all-zero "default" setting gives 800 us, which lies inside the 500 us to 1 ms window. The other defined settings run from 10 ms up to 64 s. A completion for a tag that is not outstanding can arrive after the request was reissued or retired, so two completions may turn up for one request. Such a completion is dropped and reported as a duplicate. It is never taken as a second valid answer.

Top module: `cpl_timeout_tracker`

## Requirements
- R1: After synchronous reset, all three event outputs are low and no tag is outstanding, so a completion for any tag is reported as a duplicate.
- R2: The timer tick is high on every CLK_PER_TICK-th clock edge counted from reset release: the CLK_PER_TICK-th, the 2·CLK_PER_TICK-th, and so on. Each tick lowers every armed countdown by one.
- R3: The countdown length in ticks for each `range_sel` value is: 0 → 800; 1 → 10,000; 2 → 50,000; 3 → 100,000; 4 → 1,000,000; 5 → 4,000,000; 6 → 16,000,000; 7 → 64,000,000; 8 to 15 → 800 (treated as default).
- R4: An issue on edge a loads the countdown. Counting tick edges after a, the countdown reaches zero on the N-th one. The resulting event pulse is registered on the next edge, provided no lower tag is waiting.
- R5: On a first expiry with `resend_en` = 1, `resend_valid` pulses for one cycle with the tag. The countdown then restarts from the full length and no error is raised.
- R6: An expiry of a request that was already reissued pulses `tmo_err_valid` with the tag and retires the tag.
- R7: With `resend_en` = 0, a first expiry pulses `tmo_err_valid` with the tag, retires it and issues no resend.
- R8: A completion for an outstanding tag retires it silently. This also holds for a tag that has been reissued. No later event is produced for that request.
- R9: A completion for a tag that is not outstanding pulses `dup_cpl_valid` with that tag one edge later and changes no tracking state.
- R10: A completion that lands on the same edge as its tag's expiry service wins: the tag retires with no resend and no error.
- R11: Tags whose countdowns expire together are served one per cycle, lowest tag number first.
- R12: Each event output is a one-cycle pulse per event, and `resend_valid` and `tmo_err_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request with `req_tag` is being issued |
| req_tag | input | TAG_W | Tag of the issued request |
| cpl_valid | input | 1 | A completion with `cpl_tag` has arrived |
| cpl_tag | input | TAG_W | Tag carried by the completion |
| range_sel | input | 4 | Timeout range select (0 = default) |
| resend_en | input | 1 | 1: reissue once on the first expiry; 0: retire at once |
| resend_valid | output | 1 | Pulse: reissue the request named by `resend_tag` |
| resend_tag | output | TAG_W | Tag to reissue |
| tmo_err_valid | output | 1 | Pulse: request retired by timeout |
| tmo_err_tag | output | TAG_W | Tag retired by timeout |
| dup_cpl_valid | output | 1 | Pulse: completion dropped because its tag was not outstanding |
| dup_cpl_tag | output | TAG_W | Tag of the dropped completion |

## Verification
The bench predicts the exact cycle of every pulse from the tick phase, so a timer that drops a tick or counts one extra shows up as a wrong cycle rather than a missing event. It issues three tags inside one tick period so that they expire together. A wrong arbiter would then serve them out of tag order or merge them into one pulse. It also lands a completion on the very edge where its tag's expiry would be served. A design that lets the expiry win would issue a resend and accept that completion as a valid answer. The remaining cases are completions that follow a retired tag, a reissued tag, or an already answered tag. A tracker that failed to clear or re-arm correctly would accept such a completion twice or stay silent.

// File: rtl/ctt_pkg.sv
// ctt_pkg: shared constants and the range-select decode for the tracker.
// Assumes ticks are microseconds; every countdown value fits in 26 bits.
package ctt_pkg;

    localparam int RSEL_W = 4;

    // Countdown length in ticks for a range-select code; unused codes fall back to default.
    function automatic logic [31:0] range_ticks(input logic [RSEL_W-1:0] sel);
        logic [31:0] t;
        case (sel)
            4'd1:    t = 32'd10_000;
            4'd2:    t = 32'd50_000;
            4'd3:    t = 32'd100_000;
            4'd4:    t = 32'd1_000_000;
            4'd5:    t = 32'd4_000_000;
            4'd6:    t = 32'd16_000_000;
            4'd7:    t = 32'd64_000_000;
            default: t = 32'd800;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/ctt_prescaler.sv
// ctt_prescaler: produces a one-cycle tick every CLK_PER_TICK clocks.
// Assumes the counter phase starts at zero on reset, so the first tick
// follows the CLK_PER_TICK-th edge after reset release.
module ctt_prescaler #(
    parameter int CLK_PER_TICK = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;

    generate
        if (CLK_PER_TICK == 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            logic [PW-1:0] phase;

            // Free-running phase counter that wraps at CLK_PER_TICK.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    phase <= '0;
                else if (phase == PW'(CLK_PER_TICK - 1))
                    phase <= '0;
                else
                    phase <= phase + 1'b1;
            end

            assign tick = (phase == PW'(CLK_PER_TICK - 1));

            // R2
            tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/ctt_tag_slot.sv
// ctt_tag_slot: tracking state of one tag: armed flag, reissued flag and
// countdown. Assumes the upstream never issues a tag that is still armed.
// An issue to an armed slot is ignored. Priority on one edge: completion,
// then issue, then service, then tick decrement.
module ctt_tag_slot #(
    parameter int CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             issue,
    input  logic             cpl,
    input  logic             serve,
    input  logic             reissue,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             retried,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Update arm state, reissue flag and countdown for this tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            retried <= 1'b0;
            cnt     <= '0;
        end else if (cpl && busy) begin
            busy    <= 1'b0;
            retried <= 1'b0;
        end else if (issue && !busy) begin
            busy    <= 1'b1;
            retried <= 1'b0;
            cnt     <= load_val;
        end else if (serve) begin
            if (reissue) begin
                retried <= 1'b1;
                cnt     <= load_val;
            end else begin
                busy    <= 1'b0;
                retried <= 1'b0;
            end
        end else if (busy && tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Countdown exhausted on an armed slot.
    always_comb expired = busy && (cnt == '0);

    // R8
    cpl_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl && busy) |=> !busy);

    // R5
    reissue_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serve && reissue && !cpl) |=> (busy && retried && cnt == $past(load_val)));

    // R6
    retire_on_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serve && !reissue) |=> !busy);

endmodule

// File: rtl/ctt_expiry_arb.sv
// ctt_expiry_arb: fixed-priority pick of one expired tag per cycle,
// lowest index first. Purely combinational; a request stays raised until served.
module ctt_expiry_arb #(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] gnt_idx,
    output logic                 gnt_any
);
    localparam int IW = $clog2(N);

    // Isolate the lowest set request bit.
    always_comb gnt = req & (~req + 1'b1);

    // Encode the granted index.
    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < N; i++)
            if (gnt[i]) gnt_idx = IW'(i);
    end

    always_comb gnt_any = |req;

    // R11
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && (gnt_any == (gnt != '0)));

    // R11
    grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_any |-> ((req & ((N'(1) << gnt_idx) - N'(1))) == '0));

endmodule

// File: rtl/cpl_timeout_tracker.sv
// cpl_timeout_tracker: per-tag completion timers with a single optional
// reissue, timeout retirement and duplicate-completion reporting.
// Assumes tick period CLK_PER_TICK clocks equals one microsecond, and that
// range_sel and resend_en are quasi-static. All outputs are registered.
module cpl_timeout_tracker #(
    parameter int TAG_W        = 3,
    parameter int CNT_W        = 26,
    parameter int CLK_PER_TICK = 200
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [TAG_W-1:0]          req_tag,
    input  logic                      cpl_valid,
    input  logic [TAG_W-1:0]          cpl_tag,
    input  logic [ctt_pkg::RSEL_W-1:0] range_sel,
    input  logic                      resend_en,
    output logic                      resend_valid,
    output logic [TAG_W-1:0]          resend_tag,
    output logic                      tmo_err_valid,
    output logic [TAG_W-1:0]          tmo_err_tag,
    output logic                      dup_cpl_valid,
    output logic [TAG_W-1:0]          dup_cpl_tag
);
    localparam int NUM_TAGS = 1 << TAG_W;

    logic                tick;
    logic [CNT_W-1:0]    load_val;
    logic [NUM_TAGS-1:0] busy, retried, expired, cpl_hit, serve_req, gnt;
    logic [TAG_W-1:0]    gnt_idx;
    logic                gnt_any, do_resend;

    ctt_prescaler #(.CLK_PER_TICK(CLK_PER_TICK)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    // Countdown length for the current range setting.
    always_comb load_val = CNT_W'(ctt_pkg::range_ticks(range_sel));

    generate
        for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
            // Completion addressed to this tag.
            always_comb cpl_hit[g] = cpl_valid && (cpl_tag == TAG_W'(g));

            ctt_tag_slot #(.CNT_W(CNT_W)) u_slot (
                .clk(clk), .rst_n(rst_n), .tick(tick),
                .issue(req_valid && (req_tag == TAG_W'(g))),
                .cpl(cpl_hit[g]),
                .serve(gnt[g]),
                .reissue(do_resend),
                .load_val(load_val),
                .busy(busy[g]), .retried(retried[g]), .expired(expired[g])
            );
        end
    endgenerate

    // An arriving completion withdraws its tag from service this cycle.
    always_comb serve_req = expired & ~cpl_hit;

    ctt_expiry_arb #(.N(NUM_TAGS)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(serve_req),
        .gnt(gnt), .gnt_idx(gnt_idx), .gnt_any(gnt_any)
    );

    // Reissue only for a first expiry with resend enabled.
    always_comb do_resend = resend_en && !retried[gnt_idx];

    // Register resend and timeout events for the served tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resend_valid  <= 1'b0;
            tmo_err_valid <= 1'b0;
            resend_tag    <= '0;
            tmo_err_tag   <= '0;
        end else begin
            resend_valid  <= gnt_any && do_resend;
            tmo_err_valid <= gnt_any && !do_resend;
            resend_tag    <= gnt_idx;
            tmo_err_tag   <= gnt_idx;
        end
    end

    // Flag completions whose tag is not outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dup_cpl_valid <= 1'b0;
            dup_cpl_tag   <= '0;
        end else begin
            dup_cpl_valid <= cpl_valid && !busy[cpl_tag];
            dup_cpl_tag   <= cpl_tag;
        end
    end

    // R12
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(resend_valid && tmo_err_valid));

    // R9
    dup_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !busy[cpl_tag]) |=> (dup_cpl_valid && dup_cpl_tag == $past(cpl_tag)));

    // R7
    no_resend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any && !resend_en) |=> (tmo_err_valid && !resend_valid));

    // R10
    cpl_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && expired[cpl_tag]) |=> !busy[$past(cpl_tag)]);

endmodule

// File: tb/cpl_timeout_tracker_bench.sv
// Scoreboard bench: driver tasks push expected pulses (tag and exact cycle)
// into one queue per output; a negedge monitor pops and compares.
module cpl_timeout_tracker_bench;
    localparam int TAG_W = 3;
    localparam int P     = 4;

    typedef struct {
        int     tag;
        longint cyc;
        string  req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, cpl_valid = 1'b0, resend_en = 1'b1;
    logic [TAG_W-1:0] req_tag = '0, cpl_tag = '0;
    logic [3:0] range_sel = 4'd0;
    logic resend_valid, tmo_err_valid, dup_cpl_valid;
    logic [TAG_W-1:0] resend_tag, tmo_err_tag, dup_cpl_tag;

    longint cyc = 0;
    int n_cmp = 0, n_bad = 0;
    bit mon_en = 1'b0;
    exp_t qs[3][$];

    always #2.5 clk = ~clk;

    cpl_timeout_tracker #(.TAG_W(TAG_W), .CNT_W(26), .CLK_PER_TICK(P)) u_cpl_timeout_tracker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_tag(req_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
        .range_sel(range_sel), .resend_en(resend_en),
        .resend_valid(resend_valid), .resend_tag(resend_tag),
        .tmo_err_valid(tmo_err_valid), .tmo_err_tag(tmo_err_tag),
        .dup_cpl_valid(dup_cpl_valid), .dup_cpl_tag(dup_cpl_tag)
    );

    // Edges since reset release; the tick edge is the one leaving cyc%P == P-1 (R2).
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Countdown lengths per R3.
    function automatic longint ticks_for(input int sel);
        case (sel)
            1: return 10_000;
            2: return 50_000;
            3: return 100_000;
            4: return 1_000_000;
            5: return 4_000_000;
            6: return 16_000_000;
            7: return 64_000_000;
            default: return 800;
        endcase
    endfunction

    // Cycle value at which the event pulse is seen for a load on edge a (R2, R4).
    function automatic longint event_cyc(input longint a, input longint t);
        longint k;
        k = a + 1;
        while (k % P != P - 1) k++;
        return k + (t - 1) * P + 2;
    endfunction

    task automatic push(input int k, input int tag, input longint c, input string r);
        exp_t e;
        e.tag = tag; e.cyc = c; e.req = r;
        qs[k].push_back(e);
    endtask

    task automatic check_stream(input int k, input bit v, input int tag, input string nm);
        exp_t e;
        if (v) begin
            n_cmp++;
            if (qs[k].size() == 0) begin
                n_bad++;
                $display("FAIL R12 unexpected %s pulse: actual tag=%0d cyc=%0d, expected none", nm, tag, cyc);
            end else begin
                e = qs[k].pop_front();
                if (e.tag != tag || e.cyc != cyc) begin
                    n_bad++;
                    $display("FAIL %s %s: actual tag=%0d cyc=%0d, expected tag=%0d cyc=%0d",
                             e.req, nm, tag, cyc, e.tag, e.cyc);
                end
            end
        end else if (qs[k].size() > 0 && qs[k][0].cyc < cyc) begin
            e = qs[k].pop_front();
            n_cmp++; n_bad++;
            $display("FAIL %s %s missing: actual none, expected tag=%0d cyc=%0d", e.req, nm, e.tag, e.cyc);
        end
    endtask

    // Monitor: compare every output pulse against its queue.
    always @(negedge clk) begin
        if (mon_en) begin
            if (resend_valid && tmo_err_valid) begin
                n_cmp++; n_bad++;
                $display("FAIL R12 resend and timeout together: actual 1/1, expected not both");
            end
            check_stream(0, resend_valid, int'(resend_tag), "resend");
            check_stream(1, tmo_err_valid, int'(tmo_err_tag), "timeout");
            check_stream(2, dup_cpl_valid, int'(dup_cpl_tag), "duplicate");
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190_000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual still running, expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic wait_until(input longint c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic issue(input int tag, output longint a);
        a = cyc;
        req_valid = 1'b1; req_tag = TAG_W'(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic complete(input int tag, input bit dup, input string r);
        if (dup) push(2, tag, cyc + 1, r);
        cpl_valid = 1'b1; cpl_tag = TAG_W'(tag);
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic direct(input bit act, input bit exp_v, input string what);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL R1 %s after reset: actual %0b, expected %0b", what, act, exp_v);
        end
    endtask

    initial begin
        longint a, a1, a2, g, t;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        direct(resend_valid, 1'b0, "resend_valid");
        direct(tmo_err_valid, 1'b0, "tmo_err_valid");
        direct(dup_cpl_valid, 1'b0, "dup_cpl_valid");
        mon_en = 1'b1;
        complete(0, 1'b1, "R1");
        repeat (3) @(negedge clk);

        // R4/R5/R2: reissue on first expiry, then R6 timeout, then R9 duplicate
        t = ticks_for(0);
        issue(3, a);
        g = event_cyc(a, t);
        push(0, 3, g, "R4 R5 R2");
        push(1, 3, event_cyc(g - 1, t), "R6");
        wait_until(event_cyc(g - 1, t) + 3);
        complete(3, 1'b1, "R9 R6");
        repeat (3) @(negedge clk);

        // R8: completion retires tag silently; repeat completion is duplicate
        issue(5, a);
        wait_until(a + 100);
        complete(5, 1'b0, "R8");
        wait_until(a + t * P + 40);
        complete(5, 1'b1, "R8");
        repeat (3) @(negedge clk);

        // R8: completion after a reissue is still accepted once
        issue(2, a);
        g = event_cyc(a, t);
        push(0, 2, g, "R5");
        wait_until(g + 5);
        complete(2, 1'b0, "R8");
        wait_until(g + t * P + 40);
        complete(2, 1'b1, "R8");
        repeat (3) @(negedge clk);

        // R10: completion on the service edge wins over expiry
        issue(4, a);
        g = event_cyc(a, t);
        wait_until(g - 1);
        complete(4, 1'b0, "R10");
        wait_until(g + t * P + 40);
        complete(4, 1'b1, "R10");
        repeat (3) @(negedge clk);

        // R7: resend disabled retires on first expiry
        resend_en = 1'b0;
        issue(2, a);
        push(1, 2, event_cyc(a, t), "R7");
        wait_until(event_cyc(a, t) + 3);

        // R11: three tags expire together, served 1,3,6 in order
        while (cyc % P != 0) @(negedge clk);
        issue(6, a);
        issue(3, a1);
        issue(1, a2);
        g = event_cyc(a, t);
        push(1, 1, g,     "R11");
        push(1, 3, g + 1, "R11");
        push(1, 6, g + 2, "R11");
        wait_until(g + 5);
        complete(6, 1'b1, "R11");
        repeat (3) @(negedge clk);

        // R3: unused code 9 behaves as default, code 1 gives 10,000 ticks
        range_sel = 4'd9;
        issue(7, a);
        push(1, 7, event_cyc(a, ticks_for(0)), "R3");
        wait_until(event_cyc(a, ticks_for(0)) + 3);
        range_sel = 4'd1;
        issue(0, a);
        push(1, 0, event_cyc(a, ticks_for(1)), "R3");
        wait_until(event_cyc(a, ticks_for(1)) + 3);

        repeat (5) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            while (qs[k].size() > 0) begin
                exp_t e;
                e = qs[k].pop_front();
                n_cmp++; n_bad++;
                $display("FAIL %s leftover: actual none, expected tag=%0d cyc=%0d", e.req, e.tag, e.cyc);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule